// File: doc/BRIEF.md
# Asynchronous SRAM write strober

This block sits between a synchronous request/acknowledge write port and an asynchronous static memory of 128K bytes. For each accepted request it registers the address and the write data, then drives the memory's active-low chip enable and write enable, the address lines and the data pads (value plus pad output enable). It holds all of them until the memory's minimum times have been met. It returns a single-cycle acknowledge once the whole write cycle has elapsed.

All minimum times are given in nanoseconds for three speed grades. They are turned into clock counts by ceiling division by the clock period, and no count drops below one cycle. Both strobes fall on the same edge. Every write ends with write enable rising first and chip enable rising one cycle later, so only the hold and recovery rules for a write-enable-terminated write apply. One write is in flight at a time, and a request held high is taken again in the cycle right after the acknowledge.

Top module: `sram_write_strober`

## Requirements
- R1: After reset, and whenever no write is in progress, mem_ce_n and mem_we_n are 1 and dq_oe and wr_ack are 0.
- R2: When wr_req is 1 in an idle cycle, the next cycle (write cycle 1) shows mem_ce_n and mem_we_n both at 0, with mem_addr and dq_o already equal to the request's address and data.
- R3: mem_we_n stays at 0 for exactly P cycles (cycles 1..P). P is the largest of the cycle counts for the write pulse, chip-enable-to-end, address-to-end and data-setup-to-end minima. Each count is ceil(ns / CLK_NS) with a floor of 1.
- R4: mem_ce_n is at 0 in every cycle where mem_we_n is 0, and it rises exactly one cycle after mem_we_n rises (cycle P+2).
- R5: dq_oe rises in the same cycle that mem_we_n falls and stays at 1 for the data hold count after mem_we_n rises. With a 0 ns hold that count is 1, so dq_oe falls together with mem_ce_n.
- R6: mem_addr and dq_o keep the accepted values from cycle 1 to the end of the write cycle, whatever wr_addr and wr_data do meanwhile.
- R7: wr_ack is 1 for exactly one cycle, cycle W. W is the largest of the whole-cycle count, P+1+(recovery count) and P+(data hold count)+1.
- R8: The cycle after the acknowledge is always idle. wr_req is sampled there, and a request held high starts the next write in the cycle after that.
- R9: SPEED_GRADE 0, 1 and 2 select the three timing sets: pulse 55/65/85 ns, enable-to-end and address-to-end 65/75/100 ns, data setup 30/35/45 ns, whole cycle 70/85/120 ns. Recovery is 5 ns and data hold 0 ns in every grade.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS ns |
| rst | input | 1 | Synchronous active-high reset |
| wr_req | input | 1 | Write request, sampled only when idle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_ack | output | 1 | One-cycle pulse at the end of the write cycle |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address lines |
| dq_o | output | DATA_W | Value for the data pads |
| dq_oe | output | 1 | Output enable of the data pads |

## Verification
A counter or compare point that is off by one moves a strobe edge by a whole clock. At the ports this shows up as a write-enable pulse, chip-enable tail, pad-enable window or acknowledge that is one cycle early or late, and a cycle-by-cycle timeline check catches it in the first write after reset. A wrong register capture leaves the address or data outputs following the inputs after cycle 1, and that is visible one cycle after the inputs are scrambled. Running all three grades side by side with different clock counts shows whether the grade selection reaches each compare point.

// File: rtl/sram_write_strober.sv
module sram_write_strober #(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 10,
  parameter int SPEED_GRADE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PULSE_NS = (SPEED_GRADE == 0) ? 55 : (SPEED_GRADE == 1) ? 65 : 85;
  localparam int CEEND_NS = (SPEED_GRADE == 0) ? 65 : (SPEED_GRADE == 1) ? 75 : 100;
  localparam int ADEND_NS = CEEND_NS;
  localparam int SETUP_NS = (SPEED_GRADE == 0) ? 30 : (SPEED_GRADE == 1) ? 35 : 45;
  localparam int CYCLE_NS = (SPEED_GRADE == 0) ? 70 : (SPEED_GRADE == 1) ? 85 : 120;
  localparam int RECOV_NS = 5;
  localparam int DHOLD_NS = 0;

  localparam int P_CYC  = imax(imax(ns2cyc(PULSE_NS), ns2cyc(CEEND_NS)),
                               imax(ns2cyc(ADEND_NS), ns2cyc(SETUP_NS)));
  localparam int RC_CYC = ns2cyc(RECOV_NS);
  localparam int DH_CYC = ns2cyc(DHOLD_NS);
  localparam int W_CYC  = imax(ns2cyc(CYCLE_NS),
                               imax(P_CYC + 1 + RC_CYC, P_CYC + DH_CYC + 1));
  localparam int CNT_W  = $clog2(W_CYC + 1);

  localparam logic [CNT_W-1:0] WE_END = CNT_W'(P_CYC);
  localparam logic [CNT_W-1:0] CE_END = CNT_W'(P_CYC + 1);
  localparam logic [CNT_W-1:0] OE_END = CNT_W'(P_CYC + DH_CYC);
  localparam logic [CNT_W-1:0] ACK_AT = CNT_W'(W_CYC - 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(W_CYC);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      mem_we_n <= 1'b1;
      mem_ce_n <= 1'b1;
      dq_oe    <= 1'b0;
      wr_ack   <= 1'b0;
      mem_addr <= '0;
      dq_o     <= '0;
    end else begin
      wr_ack <= 1'b0;
      if (!busy) begin
        if (wr_req) begin
          busy     <= 1'b1;
          cnt      <= CNT_W'(1);
          mem_addr <= wr_addr;
          dq_o     <= wr_data;
          mem_we_n <= 1'b0;
          mem_ce_n <= 1'b0;
          dq_oe    <= 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == WE_END) mem_we_n <= 1'b1;
        if (cnt == CE_END) mem_ce_n <= 1'b1;
        if (cnt == OE_END) dq_oe    <= 1'b0;
        if (cnt == ACK_AT) wr_ack   <= 1'b1;
        if (cnt == LAST)   busy     <= 1'b0;
      end
    end
  end

  p_strobes_fall_together_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $fell(mem_ce_n));

  p_ce_covers_we_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  p_ce_follows_we_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |=> $rose(mem_ce_n));

  p_pads_on_during_we_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> dq_oe);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(dq_o)));

  p_ack_single_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> !wr_ack);

  p_ack_after_release_r7: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (mem_ce_n && mem_we_n && !dq_oe));

  p_gap_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    wr_ack |=> (mem_ce_n && mem_we_n));

endmodule

// File: tb/sram_write_strober_bench.sv
`timescale 1ns/1ps
module sram_write_strober_bench;
  localparam int TCK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0]       req = '0;
  logic [2:0][16:0] a_in = '0;
  logic [2:0][7:0]  d_in = '0;
  logic [2:0]       ack, ce_n, we_n, oe;
  logic [2:0][16:0] a_out;
  logic [2:0][7:0]  d_out;

  for (genvar g = 0; g < 3; g++) begin : gr
    sram_write_strober #(.ADDR_W(17), .DATA_W(8), .CLK_NS(TCK), .SPEED_GRADE(g))
      u_sram_write_strober (
        .clk(clk), .rst(rst), .wr_req(req[g]), .wr_addr(a_in[g]), .wr_data(d_in[g]),
        .wr_ack(ack[g]), .mem_ce_n(ce_n[g]), .mem_we_n(we_n[g]),
        .mem_addr(a_out[g]), .dq_o(d_out[g]), .dq_oe(oe[g]));
  end

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + TCK - 1) / TCK;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int pulse_len(input int g);
    int wp [3] = '{55, 65, 85};
    int ce [3] = '{65, 75, 100};
    int dw [3] = '{30, 35, 45};
    return mx(mx(cyc(wp[g]), cyc(ce[g])), cyc(dw[g]));
  endfunction

  function automatic int cycle_len(input int g);
    int wc [3] = '{70, 85, 120};
    int p;
    p = pulse_len(g);
    return mx(cyc(wc[g]), mx(p + 1 + cyc(5), p + cyc(0) + 1));
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input int g, input string rq);
    chk(ce_n[g] == 1'b1, {rq, " ce_n idle"}, ce_n[g], 1);
    chk(we_n[g] == 1'b1, {rq, " we_n idle"}, we_n[g], 1);
    chk(oe[g]   == 1'b0, {rq, " oe idle"}, oe[g], 0);
    chk(ack[g]  == 1'b0, {rq, " ack idle"}, ack[g], 0);
  endtask

  task automatic write_one(input int g, input logic [16:0] a, input logic [7:0] d, input bit drop);
    int p, w, low;
    p = pulse_len(g);
    w = cycle_len(g);
    low = 0;
    @(negedge clk);
    chk_idle(g, "R8");
    req[g] = 1'b1; a_in[g] = a; d_in[g] = d;
    for (int k = 1; k <= w; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(ce_n[g] == 1'b0 && we_n[g] == 1'b0, "R2 strobes low", {ce_n[g], we_n[g]}, 0);
        chk(a_out[g] == a && d_out[g] == d, "R2 addr/data", int'(a_out[g]), int'(a));
      end
      if (we_n[g] == 1'b0) low++;
      chk(we_n[g] == ((k <= p) ? 1'b0 : 1'b1), "R3 we_n", we_n[g], (k <= p) ? 0 : 1);
      chk(ce_n[g] == ((k <= p + 1) ? 1'b0 : 1'b1), "R4 ce_n", ce_n[g], (k <= p + 1) ? 0 : 1);
      chk(oe[g] == ((k <= p + 1) ? 1'b1 : 1'b0), "R5 dq_oe", oe[g], (k <= p + 1) ? 1 : 0);
      chk(ack[g] == ((k == w) ? 1'b1 : 1'b0), "R7 wr_ack", ack[g], (k == w) ? 1 : 0);
      chk(a_out[g] == a, "R6 mem_addr", int'(a_out[g]), int'(a));
      chk(d_out[g] == d, "R6 dq_o", int'(d_out[g]), int'(d));
      if (k == 1) begin a_in[g] = ~a; d_in[g] = ~d; end
    end
    chk(low == p, "R9 pulse length for grade", low, p);
    if (drop) req[g] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int g = 0; g < 3; g++) chk_idle(g, "R1 reset");
    rst = 1'b0;
    for (int g = 0; g < 3; g++) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk_idle(g, "R1 no request");
      end
      write_one(g, 17'h00000, 8'h00, 1'b0);
      write_one(g, 17'h1FFFF, 8'hFF, 1'b0);
      write_one(g, 17'h0AAAA, 8'h55, 1'b1);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk_idle(g, "R1 after drop");
      end
      for (int i = 0; i < 6; i++)
        write_one(g, 17'(i * 21851 + g), 8'(1 << i), (i == 5));
      @(negedge clk);
      chk_idle(g, "R8 final gap");
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule